// File: doc/BRIEF.md
# Cascadable Serial/Parallel Lane

This block converts between a single-data-rate serial bit stream and short parallel words. It holds two identical converter units. Each unit has its own receive shift register (serial to parallel) and its own transmit shift register (parallel to serial), each four bits wide. Used alone, the low unit handles words of 2, 3 or 4 bits. When the lane runs in cascade mode, which is meant for differential pairs, the two units are chained. The low unit then holds the low-order bits and the high unit the high-order bits, giving words of 5 to 8 bits.

Every serial bit moves on the rising edge of one fast clock. A word strobe, generated outside and pulsed once every N fast cycles (N being the programmed width), marks the word boundary for both directions. On the receive side, the strobe captures the last N serial bits. The oldest of those bits becomes bit 0. On the transmit side, the strobe loads the parallel input word, which is then sent LSB first. A bit-slip pulse adds one bit of delay ahead of the receive capture, so software or a training loop can walk the word boundary into place.

Top module: `sdes_lane`

## Requirements
- R1: During and after a synchronous active-low reset, `par_out` is 0, `par_out_valid` is 0 and `ser_out` is 0. The width starts at 4, which is valid for single mode, and the slip offset starts at 0.
- R2: A width write (`cfg_we`) is accepted only if the value is legal for the current mode: 2 to 4 when `cascade_en`=0, and 5 to 8 when `cascade_en`=1. Any other value is dropped and the previous width stays in force.
- R3: For a strobe sampled at edge t with width N and slip offset 0, `par_out` after edge t+1 holds the serial bits sampled at edges t-N+1 … t. The bit sampled at t-N+1 sits in bit 0, the one sampled at t sits in bit N-1, and bits N and above are 0.
- R4: In cascade mode the two units form one 5 to 8 bit word. Bits 3:0 come from the low unit, bits 7:4 come from the high unit, and the received word obeys the same bit order as R3.
- R5: A strobe with `par_in_valid`=1 loads `par_in`. `ser_out` then shows bit 0 after that same edge, and bit j after j further edges, for j < N. Bits N and above are never sent.
- R6: A strobe with `par_in_valid`=0 loads an all-zero word, so `ser_out` is 0 for the following N bit times.
- R7: Each `bitslip` pulse raises the receive delay by one bit, modulo N. With offset s, the word captured at edge t holds the bits sampled at t-s-N+1 … t-s. An accepted width write clears the offset to 0.
- R8: `par_out_valid` is high for exactly one cycle, two edges after each strobe edge, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cascade_en | input | 1 | 1 chains both units into one 5 to 8 bit word |
| cfg_we | input | 1 | Width write enable |
| cfg_width | input | 4 | Requested word width |
| bitslip | input | 1 | One-cycle pulse adding one bit of receive delay |
| strobe | input | 1 | Word boundary pulse, once every N cycles |
| ser_in | input | 1 | Serial receive data |
| par_out | output | 8 | Received parallel word |
| par_out_valid | output | 1 | One-cycle pulse marking a new `par_out` |
| par_in | input | 8 | Parallel word to transmit |
| par_in_valid | input | 1 | `par_in` holds data at the strobe |
| ser_out | output | 1 | Serial transmit data |

## Verification
The hardest state to reach from the ports is the deepest receive delay in cascade mode. There the width is 8 and the slip offset is 7, so the captured word spans both units and is fed from the last tap of the delay line. The stimulus writes the width first, then issues seven slip pulses while the strobe is quiet, and only then streams a known pseudo-random bit sequence. Each captured word is compared against bits that were sent seven cycles before the usual window. Offset wrap-around is reached the same way: three pulses at width 3 must bring the offset back to zero.

// File: rtl/sdes_pkg.sv
// Shared sizing for the serial/parallel lane.
// Assumes a lane built from exactly two equal converter units.
package sdes_pkg;
    localparam int SD_UNIT_W = 4;                        // bits per converter unit
    localparam int SD_UNITS  = 2;                        // low unit and high unit
    localparam int SD_LANE_W = SD_UNIT_W * SD_UNITS;     // widest cascaded word
    localparam int SD_CNT_W  = $clog2(SD_LANE_W + 1);    // bits for a width value
    localparam int SD_MIN_W  = 2;                        // narrowest single word
endpackage

// File: rtl/sdes_width_cfg.sv
// Word width register and bit-slip offset.
// Accepts a width only when it is legal for the mode present during the write.
// Keeps the slip offset below the width.
// Assumes cascade_en is held steady while a width write is under way.
module sdes_width_cfg #(
    parameter int UNIT_W = sdes_pkg::SD_UNIT_W,
    parameter int CNT_W  = sdes_pkg::SD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cascade_en,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             bitslip,
    output logic [CNT_W-1:0] width_q,
    output logic [CNT_W-1:0] slip_q
);
    logic legal;
    logic slip_wrap;

    // Decide whether the requested width belongs to the legal set of the current mode.
    always_comb begin
        if (cascade_en) begin
            legal = (cfg_width >= CNT_W'(UNIT_W + 1)) && (cfg_width <= CNT_W'(2 * UNIT_W));
        end else begin
            legal = (cfg_width >= CNT_W'(sdes_pkg::SD_MIN_W)) && (cfg_width <= CNT_W'(UNIT_W));
        end
    end

    assign slip_wrap = (slip_q == width_q - CNT_W'(1));

    // Hold the width; step the slip offset modulo the width, and clear it on a new width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= CNT_W'(UNIT_W);
            slip_q  <= '0;
        end else if (cfg_we && legal) begin
            width_q <= cfg_width;
            slip_q  <= '0;
        end else if (bitslip) begin
            slip_q  <= slip_wrap ? '0 : slip_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sdes_des_unit.sv
// One receive converter unit: a shift register that moves toward bit 0.
// The newest bit enters at the top, so the oldest bit lands in bit 0.
// Assumes the caller chooses the incoming bit: the serial line, or the unit above when cascaded.
module sdes_des_unit #(
    parameter int UNIT_W = sdes_pkg::SD_UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_in,
    output logic [UNIT_W-1:0] sr_q
);
    // Shift one bit per fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {shift_in, sr_q[UNIT_W-1:1]};
        end
    end
endmodule

// File: rtl/sdes_ser_unit.sv
// One transmit converter unit: loads a slice of the word on the strobe.
// Between loads it shifts toward bit 0, and bit 0 is the unit's outgoing bit.
// Assumes the caller supplies the fill bit: zero, or the unit above when cascaded.
module sdes_ser_unit #(
    parameter int UNIT_W = sdes_pkg::SD_UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [UNIT_W-1:0] load_word,
    input  logic              chain_in,
    output logic              tail
);
    logic [UNIT_W-1:0] sr_q;

    // Load on the strobe; otherwise shift LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else begin
            sr_q <= {chain_in, sr_q[UNIT_W-1:1]};
        end
    end

    assign tail = sr_q[0];
endmodule

// File: rtl/sdes_lane.sv
// Two-unit serial/parallel lane with cascade mode.
// Receive path: slip delay line, then two shift units, then a capture register two edges after the strobe.
// Transmit path: two loadable shift units, with the low unit driving ser_out.
// Assumes the strobe arrives once every N cycles and is synchronous to clk.
module sdes_lane #(
    parameter int UNIT_W = sdes_pkg::SD_UNIT_W,
    localparam int UNITS  = sdes_pkg::SD_UNITS,
    localparam int LANE_W = UNIT_W * UNITS,
    localparam int CNT_W  = $clog2(LANE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cascade_en,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_width,
    input  logic              bitslip,
    input  logic              strobe,
    input  logic              ser_in,
    output logic [LANE_W-1:0] par_out,
    output logic              par_out_valid,
    input  logic [LANE_W-1:0] par_in,
    input  logic              par_in_valid,
    output logic              ser_out
);
    logic [CNT_W-1:0]  width_q;
    logic [CNT_W-1:0]  slip_q;
    logic [LANE_W-2:0] dly_q;
    logic              tap;
    logic [UNIT_W-1:0] des_q [UNITS];
    logic [UNITS-1:0]  des_in;
    logic              strobe_d;
    logic [LANE_W-1:0] lane_bits;
    logic [CNT_W-1:0]  shamt;
    logic [LANE_W-1:0] load_word;
    logic [UNITS-1:0]  ser_tail;
    logic [UNITS-1:0]  ser_chain;

    sdes_width_cfg #(.UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cascade_en (cascade_en),
        .cfg_we     (cfg_we),
        .cfg_width  (cfg_width),
        .bitslip    (bitslip),
        .width_q    (width_q),
        .slip_q     (slip_q)
    );

    // Slip delay line: keeps the last LANE_W-1 serial bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= {dly_q[LANE_W-3:0], ser_in};
        end
    end

    // Pick the delay tap given by the slip offset.
    always_comb begin
        tap = ser_in;
        for (int k = 0; k < LANE_W - 1; k++) begin
            if (slip_q == CNT_W'(k + 1)) tap = dly_q[k];
        end
    end

    generate
        for (genvar u = 0; u < UNITS; u++) begin : g_des
            if (u == UNITS - 1) begin : g_top
                assign des_in[u] = tap;
            end else begin : g_low
                assign des_in[u] = cascade_en ? des_q[u+1][0] : tap;
            end
            sdes_des_unit #(.UNIT_W(UNIT_W)) u_unit (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_in (des_in[u]),
                .sr_q     (des_q[u])
            );
        end
    endgenerate

    // Line the newest N received bits up with bit 0 for the current mode.
    always_comb begin
        if (cascade_en) begin
            lane_bits = {des_q[1], des_q[0]};
            shamt     = CNT_W'(LANE_W) - width_q;
        end else begin
            lane_bits = {{UNIT_W{1'b0}}, des_q[0]};
            shamt     = CNT_W'(UNIT_W) - width_q;
        end
    end

    // Capture the received word one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d      <= 1'b0;
            par_out_valid <= 1'b0;
            par_out       <= '0;
        end else begin
            strobe_d      <= strobe;
            par_out_valid <= strobe_d;
            if (strobe_d) par_out <= lane_bits >> shamt;
        end
    end

    assign load_word = par_in_valid ? par_in : '0;

    generate
        for (genvar u = 0; u < UNITS; u++) begin : g_ser
            if (u == UNITS - 1) begin : g_top
                assign ser_chain[u] = 1'b0;
            end else begin : g_low
                assign ser_chain[u] = cascade_en ? ser_tail[u+1] : 1'b0;
            end
            sdes_ser_unit #(.UNIT_W(UNIT_W)) u_unit (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (strobe),
                .load_word (load_word[u*UNIT_W +: UNIT_W]),
                .chain_in  (ser_chain[u]),
                .tail      (ser_tail[u])
            );
        end
    endgenerate

    assign ser_out = ser_tail[0];
endmodule

// File: rtl/sdes_lane_chk.sv
// Property checker for sdes_lane, attached with bind.
// Assumes the defaults from sdes_pkg.
module sdes_lane_chk #(
    parameter int UNIT_W = sdes_pkg::SD_UNIT_W,
    parameter int LANE_W = sdes_pkg::SD_LANE_W,
    parameter int CNT_W  = sdes_pkg::SD_CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cascade_en,
    input logic              cfg_we,
    input logic [CNT_W-1:0]  cfg_width,
    input logic              strobe,
    input logic              par_in_valid,
    input logic [LANE_W-1:0] par_out,
    input logic              par_out_valid,
    input logic              ser_out,
    input logic [CNT_W-1:0]  width_q,
    input logic [CNT_W-1:0]  slip_q
);
    logic req_ok;

    // Spec-side legality of a width request.
    always_comb begin
        if (cascade_en) req_ok = (int'(cfg_width) > UNIT_W) && (int'(cfg_width) <= LANE_W);
        else            req_ok = (int'(cfg_width) >= 2) && (int'(cfg_width) <= UNIT_W);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!par_out_valid && !ser_out && par_out == '0));

    assert_width_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(width_q) >= 2) && (int'(width_q) <= LANE_W));

    assert_reject_keeps_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !req_ok) |=> $stable(width_q));

    assert_accept_loads_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && req_ok) |=> (width_q == $past(cfg_width)));

    assert_upper_bits_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        par_out_valid |-> ((par_out >> $past(width_q)) == '0));

    assert_idle_word_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !par_in_valid) |=> !ser_out);

    assert_slip_below_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slip_q < width_q);

    assert_valid_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        par_out_valid == $past(strobe, 2));
endmodule

bind sdes_lane sdes_lane_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cascade_en    (cascade_en),
    .cfg_we        (cfg_we),
    .cfg_width     (cfg_width),
    .strobe        (strobe),
    .par_in_valid  (par_in_valid),
    .par_out       (par_out),
    .par_out_valid (par_out_valid),
    .ser_out       (ser_out),
    .width_q       (width_q),
    .slip_q        (slip_q)
);

// File: tb/sdes_lane_tb.sv
`timescale 1ns/1ps
module sdes_lane_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cascade_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_width = 4'd0;
    logic       bitslip = 1'b0;
    logic       strobe = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_out;
    logic       par_out_valid;
    logic [7:0] par_in = 8'd0;
    logic       par_in_valid = 1'b0;
    logic       ser_out;

    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic       bits [0:255];

    always #4 clk = ~clk;

    sdes_lane u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cascade_en    (cascade_en),
        .cfg_we        (cfg_we),
        .cfg_width     (cfg_width),
        .bitslip       (bitslip),
        .strobe        (strobe),
        .ser_in        (ser_in),
        .par_out       (par_out),
        .par_out_valid (par_out_valid),
        .par_in        (par_in),
        .par_in_valid  (par_in_valid),
        .ser_out       (ser_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic gen_bit(output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    task automatic set_width(input logic casc, input int w);
        cascade_en = casc;
        cfg_width  = 4'(w);
        cfg_we     = 1'b1;
        @(negedge clk);
        cfg_we     = 1'b0;
    endtask

    task automatic slips(input int k);
        for (int i = 0; i < k; i++) begin
            bitslip = 1'b1;
            @(negedge clk);
            bitslip = 1'b0;
        end
    endtask

    // Receive scenario: stream bits with a strobe every n cycles; check each word after the first.
    task automatic run_des(input int n, input int off, input int nwords, input string req);
        int   total;
        bit   pend;
        int   pend_t;
        logic [7:0] exp_w;
        total = n * nwords;
        pend  = 1'b0;
        pend_t = 0;
        for (int t = 0; t <= total; t++) begin
            logic b;
            if (t < total) gen_bit(b);
            else b = 1'b0;
            bits[t] = b;
            ser_in  = b;
            strobe  = (t < total) && ((t % n) == n - 1);
            @(negedge clk);
            if (pend) begin
                chk(32'(par_out_valid), 32'd1, {req, " R8 valid pulse"});
                if (pend_t >= 2 * n - 1) begin
                    exp_w = 8'd0;
                    for (int i = 0; i < n; i++) exp_w[i] = bits[pend_t - off - n + 1 + i];
                    chk(32'(par_out), 32'(exp_w), {req, " word"});
                end
            end else if (t > 0) begin
                chk(32'(par_out_valid), 32'd0, {req, " R8 idle"});
            end
            pend   = strobe;
            pend_t = t;
        end
        strobe = 1'b0;
    endtask

    // Transmit scenario: load nwords words and check each bit time.
    task automatic run_ser(input int n, input int nwords, input logic vld, input string req);
        for (int w = 0; w < nwords; w++) begin
            logic [7:0] word;
            logic [7:0] exp_w;
            for (int i = 0; i < 8; i++) begin
                logic b;
                gen_bit(b);
                word[i] = b;
            end
            exp_w        = vld ? word : 8'd0;
            par_in       = word;
            par_in_valid = vld;
            strobe       = 1'b1;
            @(negedge clk);
            strobe       = 1'b0;
            par_in_valid = 1'b0;
            chk(32'(ser_out), 32'(exp_w[0]), {req, " bit0"});
            for (int j = 1; j < n; j++) begin
                @(negedge clk);
                chk(32'(ser_out), 32'(exp_w[j]), {req, " bit"});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(par_out), 32'd0, "R1 par_out after reset");
        chk(32'(par_out_valid), 32'd0, "R1 valid after reset");
        chk(32'(ser_out), 32'd0, "R1 ser_out after reset");
        run_des(4, 0, 4, "R1 default width 4 / R3");

        set_width(1'b0, 2);
        run_des(2, 0, 6, "R3 width 2");
        run_ser(2, 4, 1'b1, "R5 width 2");

        set_width(1'b0, 3);
        set_width(1'b0, 6);
        run_des(3, 0, 4, "R2 single rejects 6");
        run_ser(3, 3, 1'b1, "R5 width 3");

        slips(1);
        run_des(3, 1, 4, "R7 slip 1");
        slips(2);
        run_des(3, 0, 4, "R7 wrap to 0");

        set_width(1'b1, 7);
        set_width(1'b1, 3);
        set_width(1'b1, 9);
        run_des(7, 0, 3, "R2 R4 cascade width 7");
        run_ser(7, 3, 1'b1, "R4 R5 cascade width 7");

        set_width(1'b1, 8);
        run_des(8, 0, 3, "R4 cascade width 8");
        slips(7);
        run_des(8, 7, 3, "R7 deepest slip");
        slips(2);
        set_width(1'b1, 5);
        run_des(5, 0, 4, "R7 cleared by width write");
        run_ser(5, 3, 1'b1, "R5 cascade width 5");
        run_ser(5, 2, 1'b0, "R6 idle word cascade");

        set_width(1'b0, 4);
        run_ser(4, 2, 1'b0, "R6 idle word single");
        run_ser(4, 2, 1'b1, "R5 width 4");
        run_des(4, 0, 3, "R3 width 4 again");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule